// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block holds a programmed SDRAM mode word and turns each burst request into the column addresses the burst visits, one per clock. A controller loads the mode word with a strobe, then issues a start strobe carrying the first column and a read/write flag. From the next cycle the block presents one column per cycle with a valid flag. A last-beat flag marks the final column of a fixed-length burst.

The mode word sets the burst length (1, 2, 4, 8 or a whole 256-column page), the ordering (sequential or interleaved), the CAS latency and a write mode in which every write touches one column only. A fixed-length burst stays inside an aligned block of columns equal to its length. A page burst runs round the page until a stop input ends it. Settings that are not defined raise a reserved flag. A start issued under such a setting yields no beats and pulses an error output instead.

Top module: `sdram_burst_seq`

## Requirements
- R1: Mode bits 2:0 pick the burst length: 000 gives 1 beat, 001 gives 2, 010 gives 4, 011 gives 8, 111 gives a full page. A burst of length N presents exactly N valid beats on consecutive cycles.
- R2: With mode bit 3 at 0 the order is sequential: beat k presents the block base plus ((start low bits + k) mod N). Beat 0 is the start column and appears in the cycle after the start strobe.
- R3: With mode bit 3 at 1 the order is interleaved: beat k presents the block base plus (start low bits XOR k).
- R4: Every beat of an N-beat burst keeps the column bits above the low log2(N) bits equal to those of the start column. Bits 7:1 are fixed for N=2, bits 7:2 for N=4 and bits 7:3 for N=8.
- R5: `col_last` is high together with the final beat of a fixed-length burst and low on every other beat. `col_valid` is low from the cycle after the last beat.
- R6: With mode bit 9 at 1 a write burst has one beat (the start column, with `col_last`), while a read still uses the programmed length.
- R7: A full-page burst advances sequentially from 255 to 0 without stopping and never raises `col_last`.
- R8: `cas_lat` presents mode bits 6:4 as a latency when they are 001, 010 or 011 (1, 2 or 3). Any other code presents 0 and counts as reserved.
- R9: `mode_reserved` is high, from the cycle after the load, when the stored word has a length code of 100, 101 or 110, a full page with interleaved order, a nonzero value in bits 8:7, or a reserved CAS code.
- R10: A start while `mode_reserved` is high produces no beats, cancels any burst in progress, and pulses `start_err` high for exactly the following cycle.
- R11: A start accepted while a burst is active drops the rest of that burst, and the new burst's beat 0 appears in the next cycle.
- R12: After reset no beat is valid, `start_err` is low, the stored mode word is zero, `cas_lat` is 0 and `mode_reserved` is 1.
- R13: Loading a new mode word during a burst does not change the length, order or columns of that burst.
- R14: `stop` high at a clock edge ends the burst in progress: the beat shown in that cycle is its final one. A start in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_load | input | 1 | Store `mode_word` at this edge |
| mode_word | input | 12 | Mode word, bit 0 lowest |
| start | input | 1 | Begin a burst at this edge |
| start_col | input | 8 | First column of the burst |
| start_write | input | 1 | 1 for a write burst, 0 for a read |
| stop | input | 1 | End the burst in progress |
| col_out | output | 8 | Column of the current beat |
| col_valid | output | 1 | `col_out` holds a beat |
| col_last | output | 1 | Current beat ends a fixed-length burst |
| cas_lat | output | 3 | Decoded CAS latency, 0 when reserved |
| mode_reserved | output | 1 | Stored mode word is a reserved setting |
| start_err | output | 1 | Previous-cycle start was refused |

## Verification
Two functions can fall in the same cycle: a new start and the running burst's progress. That progress is either its final beat or a cancellation because the mode has become reserved. The bench issues a fresh start two beats into an eight-beat burst. It expects the abandoned beats without `col_last`, followed at once by the full new sequence. It also loads a reserved word mid-burst, checks that the running burst completes untouched, then starts again and expects the beats to stop the next cycle with a single `start_err` pulse. A scoreboard predicts every beat from the length, order and start column and compares it as it appears.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;

  typedef enum logic [2:0] {
    BL_ONE,
    BL_TWO,
    BL_FOUR,
    BL_EIGHT,
    BL_PAGE
  } burst_len_e;

  typedef struct packed {
    burst_len_e  len;
    logic        interleave;
    logic        write_single;
    logic [2:0]  cas;
    logic        reserved;
  } mode_fields_t;

endpackage

// File: rtl/sdram_mode_decode.sv
module sdram_mode_decode
  import sdram_burst_pkg::*;
#(
  parameter int MODE_W = 12
) (
  input  logic [MODE_W-1:0] word,
  output mode_fields_t      fields
);

  logic len_bad;
  logic cas_bad;

  always_comb begin
    len_bad = 1'b0;
    unique case (word[2:0])
      3'b000:  fields.len = BL_ONE;
      3'b001:  fields.len = BL_TWO;
      3'b010:  fields.len = BL_FOUR;
      3'b011:  fields.len = BL_EIGHT;
      3'b111:  fields.len = BL_PAGE;
      default: begin
        fields.len = BL_ONE;
        len_bad    = 1'b1;
      end
    endcase

    cas_bad = 1'b0;
    unique case (word[6:4])
      3'b001, 3'b010, 3'b011: fields.cas = word[6:4];
      default: begin
        fields.cas = 3'd0;
        cas_bad    = 1'b1;
      end
    endcase

    fields.interleave   = word[3];
    fields.write_single = word[9];
    fields.reserved     = len_bad | cas_bad | (word[8:7] != 2'b00)
                        | ((word[2:0] == 3'b111) & word[3]);
  end

endmodule

// File: rtl/sdram_col_gen.sv
module sdram_col_gen
  import sdram_burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             cancel,
  input  logic [COL_W-1:0] launch_col,
  input  logic             one_beat,
  input  burst_len_e       len,
  input  logic             interleave,
  input  logic             stop,
  output logic [COL_W-1:0] col,
  output logic             valid,
  output logic             last
);

  localparam logic [COL_W-1:0] PAGE_MASK = {COL_W{1'b1}};

  logic             active_q, active_d;
  logic [COL_W-1:0] first_q, first_d;
  logic [COL_W-1:0] mask_q, mask_d;
  logic             ilv_q, ilv_d;
  logic             page_q, page_d;
  logic [COL_W-1:0] beat_q, beat_d;
  logic             upd_en;
  logic [COL_W-1:0] low;
  logic [COL_W-1:0] len_mask;

  always_comb begin
    unique case (len)
      BL_TWO:   len_mask = COL_W'(1);
      BL_FOUR:  len_mask = COL_W'(3);
      BL_EIGHT: len_mask = COL_W'(7);
      BL_PAGE:  len_mask = PAGE_MASK;
      default:  len_mask = '0;
    endcase
  end

  assign upd_en = launch | cancel | active_q;

  always_comb begin
    active_d = active_q;
    first_d  = first_q;
    mask_d   = mask_q;
    ilv_d    = ilv_q;
    page_d   = page_q;
    beat_d   = beat_q;
    if (launch) begin
      active_d = 1'b1;
      first_d  = launch_col;
      mask_d   = one_beat ? '0 : len_mask;
      ilv_d    = interleave;
      page_d   = (len == BL_PAGE) & ~one_beat;
      beat_d   = '0;
    end else if (cancel) begin
      active_d = 1'b0;
    end else if (active_q) begin
      if (stop || (!page_q && beat_q == mask_q)) begin
        active_d = 1'b0;
      end else begin
        beat_d = beat_q + COL_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      first_q  <= '0;
      mask_q   <= '0;
      ilv_q    <= 1'b0;
      page_q   <= 1'b0;
      beat_q   <= '0;
    end else if (upd_en) begin
      active_q <= active_d;
      first_q  <= first_d;
      mask_q   <= mask_d;
      ilv_q    <= ilv_d;
      page_q   <= page_d;
      beat_q   <= beat_d;
    end
  end

  assign low   = ilv_q ? (first_q ^ beat_q) : (first_q + beat_q);
  assign col   = (first_q & ~mask_q) | (low & mask_q);
  assign valid = active_q;
  assign last  = active_q & ~page_q & (beat_q == mask_q);

  a_r5_last_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> valid);

  a_r7_page_never_last: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && page_q) |-> !last);

  a_r11_beat0_is_start: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (valid && col == $past(launch_col)));

  a_r4_block_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && $past(valid) && !$past(launch)) |->
      ((col & ~mask_q) == ($past(col) & ~mask_q)));

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sdram_burst_pkg::*;
#(
  parameter int MODE_W = 12,
  parameter int COL_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_load,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              start,
  input  logic [COL_W-1:0]  start_col,
  input  logic              start_write,
  input  logic              stop,
  output logic [COL_W-1:0]  col_out,
  output logic              col_valid,
  output logic              col_last,
  output logic [2:0]        cas_lat,
  output logic              mode_reserved,
  output logic              start_err
);

  logic [MODE_W-1:0] mode_q, mode_d;
  logic              err_q, err_d;
  mode_fields_t      fields;
  logic              launch;
  logic              refuse;

  always_comb begin
    mode_d = mode_q;
    if (mode_load) mode_d = mode_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (mode_load) begin
      mode_q <= mode_d;
    end
  end

  sdram_mode_decode #(.MODE_W(MODE_W)) u_decode (
    .word   (mode_q),
    .fields (fields)
  );

  assign launch = start & ~fields.reserved;
  assign refuse = start & fields.reserved;
  assign err_d  = refuse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  sdram_col_gen #(.COL_W(COL_W)) u_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (launch),
    .cancel     (refuse),
    .launch_col (start_col),
    .one_beat   (start_write & fields.write_single),
    .len        (fields.len),
    .interleave (fields.interleave),
    .stop       (stop),
    .col        (col_out),
    .valid      (col_valid),
    .last       (col_last)
  );

  assign cas_lat       = fields.cas;
  assign mode_reserved = fields.reserved;
  assign start_err     = err_q;

  a_r10_refused_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode_reserved) |=> (start_err && !col_valid));

  a_r6_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    (start && start_write && !mode_reserved && mode_q[9]) |=> col_last);

  a_r8_cas_zero_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_lat == 3'd0) |-> mode_reserved);

  a_r10_err_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (start_err && !$past(start)) |-> 1'b0);

endmodule

// File: tb/sdram_burst_seq_test.sv
module sdram_burst_seq_test;

  typedef struct {
    logic [7:0] col;
    logic       last;
    string      tag;
  } beat_t;

  logic        clk;
  logic        rst_n;
  logic        mode_load;
  logic [11:0] mode_word;
  logic        start;
  logic [7:0]  start_col;
  logic        start_write;
  logic        stop;
  logic [7:0]  col_out;
  logic        col_valid;
  logic        col_last;
  logic [2:0]  cas_lat;
  logic        mode_reserved;
  logic        start_err;

  beat_t q[$];
  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 0;

  sdram_burst_seq uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_load     (mode_load),
    .mode_word     (mode_word),
    .start         (start),
    .start_col     (start_col),
    .start_write   (start_write),
    .stop          (stop),
    .col_out       (col_out),
    .col_valid     (col_valid),
    .col_last      (col_last),
    .cas_lat       (cas_lat),
    .mode_reserved (mode_reserved),
    .start_err     (start_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: compare each beat with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && col_valid && !done) begin
      if (q.size() == 0) begin
        check("R5 unexpected beat", 1, 0);
      end else begin
        beat_t e;
        e = q.pop_front();
        check({e.tag, " column"}, col_out, e.col);
        check({e.tag, " last flag"}, col_last, e.last);
      end
    end
  end

  function automatic logic [7:0] exp_col(input logic [7:0] c, input int k,
                                         input logic [7:0] m, input bit ilv);
    logic [7:0] lo;
    lo = ilv ? (c ^ 8'(k)) : (c + 8'(k));
    return (c & ~m) | (lo & m);
  endfunction

  task automatic push(input logic [7:0] c, input int n, input logic [7:0] m,
                      input bit ilv, input bit ends, input string tag);
    for (int k = 0; k < n; k++) begin
      beat_t b;
      b.col  = exp_col(c, k, m, ilv);
      b.last = ends && (k == n - 1);
      b.tag  = tag;
      q.push_back(b);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic load(input logic [11:0] w);
    mode_word = w;
    mode_load = 1'b1;
    tick();
    mode_load = 1'b0;
  endtask

  task automatic kick(input logic [7:0] c, input bit wr);
    start_col   = c;
    start_write = wr;
    start       = 1'b1;
    tick();
    start       = 1'b0;
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 400 && q.size() != 0; i++) tick();
    tick();
    check({tag, " scoreboard empty"}, q.size(), 0);
    check({tag, " idle after burst"}, col_valid, 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode_load = 0; mode_word = '0; start = 0;
    start_col = '0; start_write = 0; stop = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R12 reset state
    check("R12 valid", col_valid, 0);
    check("R12 start_err", start_err, 0);
    check("R12 cas", cas_lat, 0);
    check("R12 reserved", mode_reserved, 1);

    // R1 R2 R4 R8: length 4 sequential, CAS 2
    load(12'h022);
    check("R8 cas 2", cas_lat, 2);
    check("R9 defined word", mode_reserved, 0);
    push(8'h35, 4, 8'h03, 0, 1, "R2 seq len4");
    kick(8'h35, 0);
    drain("R1 len4");

    // R3: length 8 interleaved, CAS 3
    load(12'h03B);
    check("R8 cas 3", cas_lat, 3);
    push(8'h5D, 8, 8'h07, 1, 1, "R3 ilv len8");
    kick(8'h5D, 0);
    drain("R3 len8");

    // R1 R4: length 2 and 1, CAS 1
    load(12'h011);
    check("R8 cas 1", cas_lat, 1);
    push(8'h81, 2, 8'h01, 0, 1, "R4 seq len2");
    kick(8'h81, 0);
    drain("R1 len2");
    load(12'h010);
    push(8'h44, 1, 8'h00, 0, 1, "R1 len1");
    kick(8'h44, 0);
    drain("R1 len1");

    // R6: single-location writes, reads keep length 8
    load(12'h223);
    push(8'h13, 1, 8'h00, 0, 1, "R6 single write");
    kick(8'h13, 1);
    drain("R6 write");
    push(8'h13, 8, 8'h07, 0, 1, "R6 read len8");
    kick(8'h13, 0);
    drain("R6 read");

    // R7 R14: full page wraps 255 -> 0, ended by stop
    load(12'h027);
    check("R9 page seq", mode_reserved, 0);
    push(8'hFD, 5, 8'hFF, 0, 0, "R7 page wrap");
    kick(8'hFD, 0);
    repeat (4) tick();
    stop = 1'b1;
    tick();
    stop = 1'b0;
    check("R14 stopped page", col_valid, 0);
    check("R7 page beats", q.size(), 0);

    // R11: restart two beats into a length-8 burst
    load(12'h023);
    push(8'h20, 2, 8'h07, 0, 0, "R11 dropped burst");
    kick(8'h20, 0);
    tick();
    push(8'h47, 8, 8'h07, 0, 1, "R11 new burst");
    kick(8'h47, 0);
    drain("R11 restart");

    // R13: reserved load mid-burst leaves the burst intact
    load(12'h022);
    push(8'h10, 4, 8'h03, 0, 1, "R13 burst kept");
    kick(8'h10, 0);
    load(12'h024);
    check("R9 length code 100", mode_reserved, 1);
    drain("R13");

    // R10: refused start cancels burst in progress
    load(12'h023);
    push(8'h00, 2, 8'h07, 0, 0, "R10 cancelled burst");
    kick(8'h00, 0);
    load(12'h02F);
    check("R9 page interleaved", mode_reserved, 1);
    kick(8'h60, 0);
    check("R10 err pulse", start_err, 1);
    check("R10 no beat", col_valid, 0);
    tick();
    check("R10 err cleared", start_err, 0);
    check("R10 still idle", col_valid, 0);
    check("R10 scoreboard", q.size(), 0);

    // R8 R9: other reserved settings
    load(12'h0A2);
    check("R9 bits 8:7 nonzero", mode_reserved, 1);
    load(12'h042);
    check("R8 cas code 100", cas_lat, 0);
    check("R9 cas reserved", mode_reserved, 1);
    kick(8'h05, 0);
    check("R10 err on cas reserved", start_err, 1);

    repeat (2) tick();
    done = 1;
    summary();
    $finish;
  end

endmodule